// File: doc/BRIEF.md
# Dual Page Buffer Serial Command Front End

This block is the command side of a serial page-flash memory. A host drives it over a four-wire serial link in mode 0 or mode 3: an active-low select, a clock, and a data input. The block owns two page-sized SRAM buffers and a small behavioural page array. Each transaction starts with an opcode byte, continues with three address bytes, and may carry data bytes after them. All fields travel most significant bit first and are sampled on the rising serial clock.

The host can stream bytes into either buffer. It can commit a buffer to a page of the array, with or without a preceding erase. It can also combine loading and committing in a single transaction. A commit begins only when select returns high. It then holds the busy output for a fixed, parameter-set number of system clocks. During that time the array and the buffer being committed are locked, and the other buffer can still be loaded.

The page size is a static input that selects 528 or 512 bytes. The array is visible through a combinational inspection port, so that its contents can be observed.

Top module: `dual_buf_front`

## Requirements
- R1: After reset, busy is low and every array byte reads 0xFF. Buffer contents are kept across reset.
- R2: Opcode 0x84 loads buffer 0 and opcode 0x87 loads buffer 1. The first byte lands at the start offset. The start offset is address bits [9:0] when mode528=1 and bits [8:0] when mode528=0. Every other address bit is ignored. Each following data byte goes to the next offset.
- R3: After the last buffer offset (527 when mode528=1, 511 when mode528=0), loading continues at offset 0. It keeps going until select rises.
- R4: Opcode 0x83 (buffer 0) and opcode 0x86 (buffer 1) overwrite a page with buffer offsets 0 to pagesize-1. The page field is address bits [21:10] when mode528=1 and bits [20:9] when mode528=0. Its low PAGE_AW bits select the page, and all other bits are ignored.
- R5: Opcode 0x88 (buffer 0) and opcode 0x89 (buffer 1) program without erasing first. Each page byte becomes the old page byte ANDed with the buffer byte.
- R6: Opcode 0x82 (buffer 0) and opcode 0x85 (buffer 1) load data exactly as in R2 and R3. When select rises, they then erase and program the addressed page from that buffer, as in R4.
- R7: A commit starts only on the rising edge of select, and only after all three address bytes have arrived. A transaction ended earlier does nothing. Once started, busy stays high for exactly PROG_CYCLES system clocks.
- R8: While busy, a load of the other buffer is accepted, a load of the locked buffer is ignored, and every commit opcode is ignored.
- R9: Any other opcode value is ignored: no buffer, page or busy change.
- R10: With mode528=0, a commit writes page bytes 0 to 511 only, and bytes 512 to 527 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode528 | input | 1 | Static page size select: 1 = 528 bytes, 0 = 512 bytes |
| sck | input | 1 | Serial clock, sampled on its rising edge |
| csN | input | 1 | Active-low select; its rising edge starts commits |
| mosi | input | 1 | Serial data in, MSB first |
| peekPage | input | PAGE_AW | Array inspection page |
| peekByte | input | 10 | Array inspection byte offset |
| busy | output | 1 | High while a commit runs |
| peekData | output | 8 | Array byte at peekPage/peekByte |

## Verification
A wrong byte pointer or wrap limit puts data at the wrong offsets. This shows up in the page image at the inspection port right after the next commit ends. A wrong page-field slice or wrong lock state damages a page that should have stayed untouched, or leaves a target page stale. A bad busy counter shows up as a busy pulse of the wrong length. The bench compares every byte of the affected pages against a model built from the requirements. It also measures each busy pulse in clocks.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int BYTE_W  = 8;
  localparam int BUF_AW  = 10;
  localparam int PAGE_FW = 12;

  localparam logic [7:0] OP_LOAD_B0  = 8'h84;
  localparam logic [7:0] OP_LOAD_B1  = 8'h87;
  localparam logic [7:0] OP_ERPG_B0  = 8'h83;
  localparam logic [7:0] OP_ERPG_B1  = 8'h86;
  localparam logic [7:0] OP_KEEP_B0  = 8'h88;
  localparam logic [7:0] OP_KEEP_B1  = 8'h89;
  localparam logic [7:0] OP_LDPG_B0  = 8'h82;
  localparam logic [7:0] OP_LDPG_B1  = 8'h85;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LOAD,
    CMD_LOAD_PROG,
    CMD_PROG_ERASE,
    CMD_PROG_KEEP
  } cmd_e;

  typedef struct packed {
    logic                wrEn;
    logic                wrBuf;
    logic [BUF_AW-1:0]   wrPtr;
    logic [BYTE_W-1:0]   wrData;
    logic                progStart;
    logic                progBuf;
    logic                progErase;
    logic [PAGE_FW-1:0]  progPage;
  } strobe_t;
endpackage

// File: rtl/dsb_ctrl.sv
module dsb_ctrl import dsb_pkg::*; #(
  parameter int BIG_PAGE    = 528,
  parameter int SMALL_PAGE  = 512,
  parameter int PROG_CYCLES = 2000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    mode528,
  input  logic    sck,
  input  logic    csN,
  input  logic    mosi,
  output strobe_t strb,
  output logic    busy
);
  localparam int BIG_AW   = $clog2(BIG_PAGE);
  localparam int SMALL_AW = $clog2(SMALL_PAGE);
  localparam int CNT_W    = $clog2(PROG_CYCLES + 1);
  localparam logic [BUF_AW-1:0] BIG_LAST   = BUF_AW'(BIG_PAGE - 1);
  localparam logic [BUF_AW-1:0] SMALL_LAST = BUF_AW'(SMALL_PAGE - 1);

  // input synchronisers and edge detection
  logic [2:0] sckS, csS;
  logic [1:0] mosiS;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS  <= '0;
      csS   <= 3'b111;
      mosiS <= '0;
    end else begin
      sckS  <= {sckS[1:0], sck};
      csS   <= {csS[1:0], csN};
      mosiS <= {mosiS[0], mosi};
    end
  end

  logic sckRise, csRise, csFall, selected, bitIn;
  assign sckRise  = sckS[1] & ~sckS[2];
  assign csRise   = csS[1] & ~csS[2];
  assign csFall   = ~csS[1] & csS[2];
  assign selected = ~csS[1];
  assign bitIn    = mosiS[1];

  // frame state
  logic [2:0]         bitCnt;
  logic [2:0]         byteIdx;
  logic [6:0]         shReg;
  cmd_e               cmd;
  logic               bufSel;
  logic [15:0]        addrHi;
  logic               addrDone;
  logic [PAGE_FW-1:0] pageReg;
  logic [BUF_AW-1:0]  ptr;
  logic [CNT_W-1:0]   busyCnt;
  logic               busyBuf;

  logic              byteDone;
  logic [7:0]        newByte;
  logic [23:0]       fullAddr;
  logic [BUF_AW-1:0] lastIdx, startPtr;
  cmd_e              decCmd;
  logic              decBuf, decOk;

  assign busy     = (busyCnt != '0);
  assign byteDone = selected & sckRise & (bitCnt == 3'd7);
  assign newByte  = {shReg, bitIn};
  assign fullAddr = {addrHi, newByte};
  assign lastIdx  = mode528 ? BIG_LAST : SMALL_LAST;
  assign startPtr = mode528 ? BUF_AW'(fullAddr[BIG_AW-1:0])
                            : BUF_AW'(fullAddr[SMALL_AW-1:0]);

  logic unusedTopBits;
  assign unusedTopBits = ^fullAddr[23:BIG_AW+PAGE_FW];

  always_comb begin
    decCmd = CMD_NONE;
    decBuf = 1'b0;
    case (newByte)
      OP_LOAD_B0: begin decCmd = CMD_LOAD;       decBuf = 1'b0; end
      OP_LOAD_B1: begin decCmd = CMD_LOAD;       decBuf = 1'b1; end
      OP_ERPG_B0: begin decCmd = CMD_PROG_ERASE; decBuf = 1'b0; end
      OP_ERPG_B1: begin decCmd = CMD_PROG_ERASE; decBuf = 1'b1; end
      OP_KEEP_B0: begin decCmd = CMD_PROG_KEEP;  decBuf = 1'b0; end
      OP_KEEP_B1: begin decCmd = CMD_PROG_KEEP;  decBuf = 1'b1; end
      OP_LDPG_B0: begin decCmd = CMD_LOAD_PROG;  decBuf = 1'b0; end
      OP_LDPG_B1: begin decCmd = CMD_LOAD_PROG;  decBuf = 1'b1; end
      default:    begin decCmd = CMD_NONE;       decBuf = 1'b0; end
    endcase
    // the lock: loads only touch the free buffer, commits need an idle array
    if (decCmd == CMD_LOAD) decOk = !(busy && (decBuf == busyBuf));
    else                    decOk = (decCmd != CMD_NONE) && !busy;
  end

  // strobes towards the datapath
  always_comb begin
    strb           = '0;
    strb.wrEn      = byteDone && (byteIdx == 3'd4) &&
                     ((cmd == CMD_LOAD) || (cmd == CMD_LOAD_PROG));
    strb.wrBuf     = bufSel;
    strb.wrPtr     = ptr;
    strb.wrData    = newByte;
    strb.progStart = csRise && addrDone &&
                     ((cmd == CMD_LOAD_PROG) || (cmd == CMD_PROG_ERASE) ||
                      (cmd == CMD_PROG_KEEP));
    strb.progBuf   = bufSel;
    strb.progErase = (cmd != CMD_PROG_KEEP);
    strb.progPage  = pageReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteIdx  <= '0;
      shReg    <= '0;
      cmd      <= CMD_NONE;
      bufSel   <= 1'b0;
      addrHi   <= '0;
      addrDone <= 1'b0;
      pageReg  <= '0;
      ptr      <= '0;
    end else if (csFall) begin
      bitCnt   <= '0;
      byteIdx  <= '0;
      cmd      <= CMD_NONE;
      addrDone <= 1'b0;
    end else if (csRise) begin
      cmd      <= CMD_NONE;
      addrDone <= 1'b0;
    end else if (selected && sckRise) begin
      bitCnt <= bitCnt + 3'd1;
      shReg  <= {shReg[5:0], bitIn};
      if (bitCnt == 3'd7) begin
        if (byteIdx != 3'd4) byteIdx <= byteIdx + 3'd1;
        case (byteIdx)
          3'd0: begin
            cmd    <= decOk ? decCmd : CMD_NONE;
            bufSel <= decBuf;
          end
          3'd1, 3'd2: addrHi <= {addrHi[7:0], newByte};
          3'd3: begin
            addrDone <= 1'b1;
            ptr      <= startPtr;
            pageReg  <= mode528 ? fullAddr[BIG_AW +: PAGE_FW]
                                : fullAddr[SMALL_AW +: PAGE_FW];
          end
          default: begin
            if (strb.wrEn) ptr <= (ptr == lastIdx) ? '0 : ptr + 1'b1;
          end
        endcase
      end
    end
  end

  // self-timed busy window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      busyBuf <= 1'b0;
    end else if (strb.progStart) begin
      busyCnt <= CNT_W'(PROG_CYCLES);
      busyBuf <= bufSel;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // R7: busy only ever begins right after select went high
  a_r7_busy_on_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));
  // R8: no byte is ever written into the locked buffer
  a_r8_locked_buffer: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && busy) |-> (strb.wrBuf != busyBuf));
  // R8: a commit never restarts the window
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.progStart |-> !busy);
  // R3: the pointer never leaves the active page length
  a_r3_ptr_in_page: assert property (@(posedge clk) disable iff (!rstN)
    addrDone |-> (ptr <= lastIdx));
endmodule

// File: rtl/dsb_datapath.sv
module dsb_datapath import dsb_pkg::*; #(
  parameter int BIG_PAGE   = 528,
  parameter int SMALL_PAGE = 512,
  parameter int PAGE_AW    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mode528,
  input  strobe_t            strb,
  input  logic               busy,
  input  logic [PAGE_AW-1:0] peekPage,
  input  logic [BUF_AW-1:0]  peekByte,
  output logic [BYTE_W-1:0]  peekData
);
  localparam int PAGES     = 1 << PAGE_AW;
  localparam int ARR_DEPTH = PAGES * BIG_PAGE;
  localparam int ARR_AW    = $clog2(ARR_DEPTH);
  localparam logic [BUF_AW-1:0] BIG_LAST   = BUF_AW'(BIG_PAGE - 1);
  localparam logic [BUF_AW-1:0] SMALL_LAST = BUF_AW'(SMALL_PAGE - 1);

  logic               copying, copyBuf, copyErase;
  logic [BUF_AW-1:0]  copyIdx, copyLast;
  logic [PAGE_AW-1:0] copyPage;
  logic [ARR_AW-1:0]  copyAddr, peekAddr;
  logic [BYTE_W-1:0]  bufRd [2];
  logic [BYTE_W-1:0]  srcByte;

  // two page buffers, one serial write port each, read by the copy engine
  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [BYTE_W-1:0] mem [BIG_PAGE];
    always_ff @(posedge clk) begin
      if (strb.wrEn && (strb.wrBuf == 1'(b))) mem[strb.wrPtr] <= strb.wrData;
    end
    assign bufRd[b] = mem[copyIdx];
  end

  assign srcByte  = copyBuf ? bufRd[1] : bufRd[0];
  assign copyAddr = ARR_AW'(copyPage) * ARR_AW'(BIG_PAGE) + ARR_AW'(copyIdx);
  assign peekAddr = ARR_AW'(peekPage) * ARR_AW'(BIG_PAGE) + ARR_AW'(peekByte);

  logic unusedPageBits;
  assign unusedPageBits = ^strb.progPage[PAGE_FW-1:PAGE_AW];

  // copy engine: one byte per clock from the chosen buffer into the page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      copying   <= 1'b0;
      copyBuf   <= 1'b0;
      copyErase <= 1'b0;
      copyIdx   <= '0;
      copyLast  <= '0;
      copyPage  <= '0;
    end else if (strb.progStart) begin
      copying   <= 1'b1;
      copyBuf   <= strb.progBuf;
      copyErase <= strb.progErase;
      copyIdx   <= '0;
      copyLast  <= mode528 ? BIG_LAST : SMALL_LAST;
      copyPage  <= strb.progPage[PAGE_AW-1:0];
    end else if (copying) begin
      if (copyIdx == copyLast) copying <= 1'b0;
      else                     copyIdx <= copyIdx + 1'b1;
    end
  end

  // behavioural page array, erased state all ones
  logic [BYTE_W-1:0] arr [ARR_DEPTH];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ARR_DEPTH; i++) arr[i] <= '1;
    end else if (copying) begin
      arr[copyAddr] <= copyErase ? srcByte : (arr[copyAddr] & srcByte);
    end
  end

  assign peekData = (peekByte < BUF_AW'(BIG_PAGE)) ? arr[peekAddr] : '0;

  // R7: the array is only written inside the busy window
  a_r7_copy_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    copying |-> busy);
  // R8: a new commit never lands on a running copy
  a_r8_no_copy_overlap: assert property (@(posedge clk) disable iff (!rstN)
    strb.progStart |-> !copying);
  // R10: the copy index stays inside the active page length
  a_r10_copy_bound: assert property (@(posedge clk) disable iff (!rstN)
    copying |-> (copyIdx <= copyLast));
endmodule

// File: rtl/dual_buf_front.sv
module dual_buf_front import dsb_pkg::*; #(
  parameter int BIG_PAGE    = 528,
  parameter int SMALL_PAGE  = 512,
  parameter int PAGE_AW     = 2,
  parameter int PROG_CYCLES = 2000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mode528,
  input  logic               sck,
  input  logic               csN,
  input  logic               mosi,
  input  logic [PAGE_AW-1:0] peekPage,
  input  logic [BUF_AW-1:0]  peekByte,
  output logic               busy,
  output logic [BYTE_W-1:0]  peekData
);
  strobe_t strb;

  dsb_ctrl #(
    .BIG_PAGE(BIG_PAGE), .SMALL_PAGE(SMALL_PAGE), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mode528(mode528), .sck(sck), .csN(csN),
    .mosi(mosi), .strb(strb), .busy(busy)
  );

  dsb_datapath #(
    .BIG_PAGE(BIG_PAGE), .SMALL_PAGE(SMALL_PAGE), .PAGE_AW(PAGE_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .mode528(mode528), .strb(strb), .busy(busy),
    .peekPage(peekPage), .peekByte(peekByte), .peekData(peekData)
  );
endmodule

// File: tb/dual_buf_front_bench.sv
module dual_buf_front_bench;
  localparam int PROG = 1200;
  localparam int BIG  = 528;
  localparam int NPG  = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, mode528, sck, csN, mosi, busy;
  logic [1:0] peekPage;
  logic [9:0] peekByte;
  logic [7:0] peekData;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;
  int bm [2][BIG];
  int am [NPG][BIG];

  dual_buf_front #(.PAGE_AW(2), .PROG_CYCLES(PROG)) u_dual_buf_front (
    .clk(clk), .rstN(rstN), .mode528(mode528), .sck(sck), .csN(csN),
    .mosi(mosi), .peekPage(peekPage), .peekByte(peekByte),
    .busy(busy), .peekData(peekData)
  );

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      mosi = v[i];
      waitClk(2); sck = 1'b1;
      waitClk(2); sck = 1'b0;
    end
  endtask

  task automatic openFrame(logic [7:0] op, logic [23:0] a);
    csN = 1'b0; waitClk(4);
    sendByte(op); sendByte(a[23:16]); sendByte(a[15:8]); sendByte(a[7:0]);
  endtask

  task automatic closeFrame();
    waitClk(4); csN = 1'b1;
  endtask

  // data bytes (base + k*step), landing at wrapping offsets if expected
  task automatic sendData(int b, int start, int n, int base, int step,
                          bit lands, int plen);
    int p = start;
    for (int k = 0; k < n; k++) begin
      int v = (base + k * step) & 255;
      sendByte(8'(v));
      if (lands) bm[b][p] = v;
      p = (p == plen - 1) ? 0 : p + 1;
    end
  endtask

  task automatic modelProg(int b, int pg, bit erase, int plen);
    for (int i = 0; i < plen; i++)
      am[pg][i] = erase ? bm[b][i] : (am[pg][i] & bm[b][i]);
  endtask

  task automatic checkPage(int pg, string req);
    for (int i = 0; i < BIG; i++) begin
      peekPage = 2'(pg); peekByte = 10'(i); #1;
      check(req, int'(peekData), am[pg][i]);
    end
  endtask

  task automatic measureBusy(string req);
    int t = 0, len = 0;
    while (!busy && t < 20) begin waitClk(1); t++; end
    while (busy && len < PROG + 50) begin len++; waitClk(1); end
    check(req, len, PROG);
  endtask

  task automatic expectIdle(string req);
    waitClk(12);
    check(req, int'(busy), 0);
  endtask

  task automatic eraseModel();
    for (int p = 0; p < NPG; p++)
      for (int i = 0; i < BIG; i++) am[p][i] = 255;
  endtask

  initial begin
    waitClk(190000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; mode528 = 1'b1; sck = 1'b0; csN = 1'b1; mosi = 1'b0;
    peekPage = '0; peekByte = '0;
    eraseModel();
    waitClk(5); rstN = 1'b1; waitClk(5);

    // R1: reset state
    check("R1 busy", int'(busy), 0);
    checkPage(0, "R1");
    checkPage(3, "R1");

    // R2: full loads of both buffers, junk in ignored address bits
    openFrame(8'h84, 24'hFC0000);
    sendData(0, 0, BIG, 3, 7, 1'b1, BIG);
    closeFrame(); expectIdle("R2 load leaves busy low");
    openFrame(8'h87, 24'h3FAC00);
    sendData(1, 0, BIG, 90, 13, 1'b1, BIG);
    closeFrame();
    waitClk(12);

    // R3: wrap from offset 527 to 0
    openFrame(8'h84, 24'hAB0000 | 24'd525);
    sendData(0, 525, 6, 8'hA0, 1, 1'b1, BIG);
    closeFrame(); waitClk(12);

    // R4 + R7: erase-program page 2 (page field 0x012 -> page 2)
    openFrame(8'h83, (24'h2 << 22) | (24'h012 << 10) | 24'h155);
    closeFrame(); measureBusy("R7 busy length");
    modelProg(0, 2, 1'b1, BIG);
    checkPage(2, "R4/R3");

    // R5: program without erase ANDs buffer 1 into page 2
    openFrame(8'h89, 24'h002 << 10);
    closeFrame(); measureBusy("R7 busy length");
    modelProg(1, 2, 1'b0, BIG);
    checkPage(2, "R5");

    // R7: commit cut short after two address bytes
    csN = 1'b0; waitClk(4);
    sendByte(8'h83); sendByte(8'h00); sendByte(8'h04);
    closeFrame(); expectIdle("R7 short frame");
    checkPage(1, "R7 short frame");

    // R9: unknown opcode
    openFrame(8'h55, 24'h000400);
    sendData(0, 0, 3, 1, 1, 1'b0, BIG);
    closeFrame(); expectIdle("R9 unknown opcode");
    checkPage(0, "R9");

    // R8: lock behaviour during a commit of buffer 1 to page 3
    openFrame(8'h86, 24'h023 << 10);
    closeFrame();
    modelProg(1, 3, 1'b1, BIG);
    waitClk(8);
    check("R8 busy during lock test", int'(busy), 1);
    openFrame(8'h84, 24'd100);
    sendData(0, 100, 4, 8'h11, 8'h22, 1'b1, BIG);
    closeFrame(); waitClk(6);
    openFrame(8'h87, 24'd200);
    sendData(1, 200, 4, 8'h33, 1, 1'b0, BIG);
    closeFrame(); waitClk(6);
    openFrame(8'h83, 24'h001 << 10);
    closeFrame();
    check("R8 still busy", int'(busy), 1);
    while (busy) waitClk(1);
    waitClk(12);
    check("R8 ignored commit", int'(busy), 0);
    checkPage(3, "R8 locked page");
    checkPage(1, "R8 ignored commit");
    openFrame(8'h83, 24'h000 << 10);
    closeFrame(); measureBusy("R7 busy length");
    modelProg(0, 0, 1'b1, BIG);
    checkPage(0, "R8 free buffer write");
    openFrame(8'h86, 24'h001 << 10);
    closeFrame(); measureBusy("R7 busy length");
    modelProg(1, 1, 1'b1, BIG);
    checkPage(1, "R8 locked buffer write");

    // R6: load-and-program through buffer 1 with wrap
    openFrame(8'h85, (24'h000 << 10) | 24'd523);
    sendData(1, 523, 8, 8'h40, 3, 1'b1, BIG);
    closeFrame(); measureBusy("R6 busy length");
    modelProg(1, 0, 1'b1, BIG);
    checkPage(0, "R6");

    // R10 / R3 / R2 in 512-byte mode, buffers kept across reset (R1)
    mode528 = 1'b0; rstN = 1'b0; waitClk(4); rstN = 1'b1; waitClk(4);
    eraseModel();
    openFrame(8'h84, 24'h0003FE);
    sendData(0, 510, 4, 8'hE0, 1, 1'b1, 512);
    closeFrame(); waitClk(12);
    openFrame(8'h83, (24'h003 << 9) | 24'h0AB);
    closeFrame(); measureBusy("R7 busy length 512");
    modelProg(0, 3, 1'b1, 512);
    checkPage(3, "R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule